// File: doc/BRIEF.md
# Single-Cycle 32-Bit RISC Core

A 32-bit processor core that retires one instruction on every rising clock edge. Fetch, decode, register read, ALU work, data-memory access and register write-back all settle within one clock period. The program counter, the register file and the data memory are all updated on that single edge. The core implements a small load/store instruction set: five register-to-register operations (add, subtract, AND, OR and signed set-less-than), word load, word store, branch-if-equal and an absolute jump.

Instruction memory and data memory are small word arrays inside the core. They are filled through a word-wide load port, normally while reset is held. The core reports its state at the ports so that a surrounding environment can follow execution:

- the current program counter and instruction word;
- the register write it is about to commit;
- the data-memory write it is about to commit;
- a combinational peek port that reads any architectural register.

Field layout: the opcode sits in bits 31..26, the first source register (rs) in 25..21 and the second (rt) in 20..16. Register-to-register forms carry the destination (rd) in 15..11 and the function code in 5..0. Immediate forms carry a signed 16-bit value in 15..0. The jump form carries a 26-bit word target in 25..0.

Top module: `sc_core`

## Requirements
- R1: While `rst` is 1 at a clock edge, the PC becomes 0 and every register becomes 0. During reset `rf_we_o` and `dm_we_o` are 0.
- R2: Opcode 0x00 with function 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt into register rd.
- R3: Opcode 0x00 with function 0x2A writes 1 into rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R4: Opcode 0x23 writes data memory at byte address rs + sign-extended imm16 into register rt. A negative offset subtracts from rs.
- R5: Opcode 0x2B writes register rt into data memory at byte address rs + sign-extended imm16, and writes no register.
- R6: Opcode 0x04 sets the PC to PC+4+(sign-extended imm16 times 4) when rs equals rt, and to PC+4 otherwise. This holds for negative displacements.
- R7: Opcode 0x02 sets the PC to {(PC+4)[31:28], target26, 2'b00}.
- R8: Register 0 always reads as 0. Writes to it are discarded.
- R9: An opcode outside {0x00, 0x23, 0x2B, 0x04, 0x02}, or function code outside {0x20, 0x22, 0x24, 0x25, 0x2A} under opcode 0x00, writes neither a register nor memory, and advances the PC by 4.
- R10: Every non-branching instruction advances the PC by 4 in one cycle. A value loaded by one instruction is readable by the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write load_data into a memory word on this edge |
| load_imem | input | 1 | 1 selects instruction memory, 0 data memory |
| load_addr | input | LAW | Word index for the load port |
| load_data | input | 32 | Word written by the load port |
| peek_sel | input | 5 | Register number for the peek port |
| peek_data | output | 32 | Contents of the selected register (0 for register 0) |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction word at the current PC |
| rf_we_o | output | 1 | Current instruction writes the register file |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dm_we_o | output | 1 | Current instruction writes data memory |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Store data |

## Verification
The bench builds the core with 64-word instruction and data memories. This is enough room to put a jump target far from the reset address. Stored words and base registers can reach byte address 20 and beyond, so a load with a negative offset from a loaded base stays inside the array. With this depth the bench can hold small branch loops that move forward and backward, and can park each program on a jump-to-self so its final register state can be read at leisure through the peek port.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic           load_imem,
  input  logic [LAW-1:0] load_addr,
  input  logic [31:0]    load_data,
  input  logic [4:0]     peek_sel,
  output logic [31:0]    peek_data,
  output logic [31:0]    pc_o,
  output logic [31:0]    instr_o,
  output logic           rf_we_o,
  output logic [4:0]     rf_waddr_o,
  output logic [31:0]    rf_wdata_o,
  output logic           dm_we_o,
  output logic [31:0]    dm_addr_o,
  output logic [31:0]    dm_wdata_o
);
  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT} alu_fn_t;

  logic [31:0] pc;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [32];

  logic [31:0] instr;
  assign instr = imem[pc[IAW+1:2]];

  logic [5:0] opc, fn;
  logic [4:0] rs, rt, rd;
  assign opc = instr[31:26];
  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign fn  = instr[5:0];

  logic [31:0] imm_x;
  assign imm_x = {{16{instr[15]}}, instr[15:0]};

  logic [31:0] va, vb;
  assign va = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign vb = (rt == 5'd0) ? 32'd0 : regs[rt];

  logic    reg_wr, dst_rd, use_imm, from_mem, mem_wr, is_beq, is_jmp;
  alu_fn_t alu_fn;

  always_comb begin
    reg_wr   = 1'b0;
    dst_rd   = 1'b0;
    use_imm  = 1'b0;
    from_mem = 1'b0;
    mem_wr   = 1'b0;
    is_beq   = 1'b0;
    is_jmp   = 1'b0;
    alu_fn   = OP_ADD;
    case (opc)
      6'h00: begin
        dst_rd = 1'b1;
        reg_wr = 1'b1;
        case (fn)
          6'h20:   alu_fn = OP_ADD;
          6'h22:   alu_fn = OP_SUB;
          6'h24:   alu_fn = OP_AND;
          6'h25:   alu_fn = OP_OR;
          6'h2A:   alu_fn = OP_SLT;
          default: reg_wr = 1'b0;
        endcase
      end
      6'h23: begin
        reg_wr   = 1'b1;
        use_imm  = 1'b1;
        from_mem = 1'b1;
      end
      6'h2B: begin
        mem_wr  = 1'b1;
        use_imm = 1'b1;
      end
      6'h04: is_beq = 1'b1;
      6'h02: is_jmp = 1'b1;
      default: ;
    endcase
  end

  logic [31:0] opb, alu_y;
  assign opb = use_imm ? imm_x : vb;

  always_comb begin
    case (alu_fn)
      OP_SUB:  alu_y = va - opb;
      OP_AND:  alu_y = va & opb;
      OP_OR:   alu_y = va | opb;
      OP_SLT:  alu_y = {31'd0, $signed(va) < $signed(opb)};
      default: alu_y = va + opb;
    endcase
  end

  logic [31:0] mem_q, wb_val;
  logic [4:0]  wb_reg;
  assign mem_q  = dmem[alu_y[DAW+1:2]];
  assign wb_val = from_mem ? mem_q : alu_y;
  assign wb_reg = dst_rd ? rd : rt;

  logic [31:0] pc_inc, pc_br, pc_jmp, pc_nxt;
  assign pc_inc = pc + 32'd4;
  assign pc_br  = pc_inc + {imm_x[29:0], 2'b00};
  assign pc_jmp = {pc_inc[31:28], instr[25:0], 2'b00};
  assign pc_nxt = is_jmp ? pc_jmp : ((is_beq && va == vb) ? pc_br : pc_inc);

  logic do_rf, do_dm;
  assign do_rf = !rst && reg_wr;
  assign do_dm = !rst && mem_wr;

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else if (do_rf && wb_reg != 5'd0) begin
      regs[wb_reg] <= wb_val;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en && load_imem) imem[load_addr[IAW-1:0]] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_en && !load_imem) dmem[load_addr[DAW-1:0]] <= load_data;
    else if (do_dm)            dmem[alu_y[DAW+1:2]] <= vb;
  end

  assign peek_data  = (peek_sel == 5'd0) ? 32'd0 : regs[peek_sel];
  assign pc_o       = pc;
  assign instr_o    = instr;
  assign rf_we_o    = do_rf;
  assign rf_waddr_o = wb_reg;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = do_dm;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = vb;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  peek_sel,
  input logic [31:0] peek_data,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic        dm_we_o
);
  logic [5:0]  opc;
  logic [31:0] nxt_seq, jmp_tgt;
  logic        known;
  assign opc     = instr_o[31:26];
  assign nxt_seq = pc_o + 32'd4;
  assign jmp_tgt = {nxt_seq[31:28], instr_o[25:0], 2'b00};
  assign known   = (opc == 6'h00) || (opc == 6'h23) || (opc == 6'h2B) ||
                   (opc == 6'h04) || (opc == 6'h02);

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc_o == 32'd0);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |-> (!rf_we_o && !dm_we_o));
  p_store_noreg_r5: assert property (@(posedge clk) disable iff (rst) dm_we_o |-> !rf_we_o);
  p_jump_tgt_r7: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h02) |=> pc_o == $past(jmp_tgt));
  p_zero_reg_r8: assert property (@(posedge clk) (peek_sel == 5'd0) |-> peek_data == 32'd0);
  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!rf_we_o && !dm_we_o));
  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'h02 && opc != 6'h04) |=> pc_o == $past(nxt_seq));
  p_pc_align_r10: assert property (@(posedge clk) pc_o[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk chk_i (
  .clk(clk), .rst(rst), .peek_sel(peek_sel), .peek_data(peek_data),
  .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o), .dm_we_o(dm_we_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  localparam int W = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic          rst = 1'b1, load_en = 1'b0, load_imem = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0]   load_data = '0;
  logic [4:0]    peek_sel = '0;
  logic [31:0]   peek_data, pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic          rf_we_o, dm_we_o;
  logic [4:0]    rf_waddr_o;

  sc_core #(.IMEM_WORDS(W), .DMEM_WORDS(W)) dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_imem(load_imem),
    .load_addr(load_addr), .load_data(load_data), .peek_sel(peek_sel),
    .peek_data(peek_data), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] prog [W];
  logic [31:0] data [W];

  function automatic logic [31:0] enc_r(input int s, t, d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(input int word);
    return {6'h02, 26'(word)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic peek(input int r, output logic [31:0] v);
    peek_sel = 5'(r);
    #1;
    v = peek_data;
  endtask

  task automatic clear_arrays();
    for (int i = 0; i < W; i++) begin
      prog[i] = 32'd0;
      data[i] = 32'd0;
    end
  endtask

  task automatic load_all();
    rst = 1'b1;
    @(negedge clk);
    load_en = 1'b1;
    for (int i = 0; i < W; i++) begin
      load_imem = 1'b1; load_addr = AW'(i); load_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < W; i++) begin
      load_imem = 1'b0; load_addr = AW'(i); load_data = data[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_rst();
    rst = 1'b0;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    clear_arrays();
    prog[0] = enc_i(6'h23, 0, 7, 0);
    data[0] = 32'h55;
    load_all();
    #1;
    chk(pc_o == 0, "R1", "pc in reset", pc_o, 0);
    chk(!rf_we_o && !dm_we_o, "R1", "write enables in reset", {rf_we_o, dm_we_o}, 0);
    peek(7, v);
    chk(v == 0, "R1", "r7 after reset", v, 0);
    release_rst();
    chk(rf_we_o == 1'b1 && rf_wdata_o == 32'h55, "R4", "first load after reset", rf_wdata_o, 32'h55);
  endtask

  task automatic t_alu();
    logic [31:0] a, b, v;
    a = 32'hFFFF_FFF0;
    b = 32'h0000_0035;
    clear_arrays();
    data[0] = a; data[1] = b;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_i(6'h23, 0, 2, 4);
    prog[2] = enc_r(1, 2, 3, 6'h20);
    prog[3] = enc_r(1, 2, 4, 6'h22);
    prog[4] = enc_r(1, 2, 5, 6'h24);
    prog[5] = enc_r(1, 2, 6, 6'h25);
    prog[6] = enc_r(1, 2, 7, 6'h2A);
    prog[7] = enc_r(2, 1, 8, 6'h2A);
    prog[8] = enc_j(8);
    load_all();
    release_rst();
    step(2);
    chk(rf_we_o && rf_waddr_o == 3 && rf_wdata_o == a + b, "R10",
        "add uses value loaded one cycle earlier", rf_wdata_o, a + b);
    chk(pc_o == 32'd8, "R10", "pc after two instructions", pc_o, 8);
    step(7);
    peek(3, v); chk(v == a + b, "R2", "add", v, a + b);
    peek(4, v); chk(v == a - b, "R2", "sub", v, a - b);
    peek(5, v); chk(v == (a & b), "R2", "and", v, a & b);
    peek(6, v); chk(v == (a | b), "R2", "or", v, a | b);
    peek(7, v); chk(v == 32'd1, "R3", "slt negative < positive", v, 1);
    peek(8, v); chk(v == 32'd0, "R3", "slt positive < negative", v, 0);
    chk(pc_o == 32'd32, "R7", "jump to self holds", pc_o, 32);
  endtask

  task automatic t_mem();
    logic [31:0] v;
    clear_arrays();
    data[3] = 32'd16;
    data[2] = 32'h1234_5678;
    prog[0] = enc_i(6'h23, 0, 9, 12);
    prog[1] = enc_i(6'h23, 9, 10, -8);
    prog[2] = enc_i(6'h2B, 9, 10, 4);
    prog[3] = enc_i(6'h23, 0, 11, 20);
    prog[4] = enc_j(4);
    load_all();
    release_rst();
    step(1);
    chk(rf_wdata_o == 32'h1234_5678, "R4", "load with negative offset", rf_wdata_o, 32'h1234_5678);
    step(1);
    chk(dm_we_o && dm_addr_o == 32'd20, "R5", "store address", dm_addr_o, 20);
    chk(dm_wdata_o == 32'h1234_5678, "R5", "store data", dm_wdata_o, 32'h1234_5678);
    chk(!rf_we_o, "R5", "store writes no register", {31'd0, rf_we_o}, 0);
    step(3);
    peek(11, v);
    chk(v == 32'h1234_5678, "R5", "stored word reloaded", v, 32'h1234_5678);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    clear_arrays();
    data[0] = 32'd7;
    data[1] = 32'd99;
    prog[0] = enc_i(6'h23, 0, 1, 0);
    prog[1] = enc_i(6'h23, 0, 2, 0);
    prog[2] = enc_i(6'h04, 1, 2, 2);
    prog[3] = enc_i(6'h23, 0, 3, 4);
    prog[4] = enc_j(4);
    prog[5] = enc_i(6'h04, 1, 0, 5);
    prog[6] = enc_i(6'h04, 0, 0, -3);
    load_all();
    release_rst();
    step(3);
    chk(pc_o == 32'd20, "R6", "taken forward branch", pc_o, 20);
    step(1);
    chk(pc_o == 32'd24, "R6", "not-taken branch", pc_o, 24);
    step(1);
    chk(pc_o == 32'd16, "R6", "taken backward branch", pc_o, 16);
    step(1);
    chk(pc_o == 32'd16, "R7", "parked on jump", pc_o, 16);
    peek(3, v);
    chk(v == 32'd0, "R6", "skipped load left r3", v, 0);
  endtask

  task automatic t_jump();
    clear_arrays();
    prog[0]  = enc_j(16);
    prog[16] = enc_j(16);
    load_all();
    release_rst();
    step(1);
    chk(pc_o == 32'd64, "R7", "absolute jump target", pc_o, 64);
    step(1);
    chk(pc_o == 32'd64, "R7", "jump to self", pc_o, 64);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    clear_arrays();
    data[0] = 32'hDEAD_BEEF;
    prog[0] = enc_i(6'h23, 0, 0, 0);
    prog[1] = enc_i(6'h23, 0, 1, 0);
    prog[2] = enc_r(1, 1, 0, 6'h20);
    prog[3] = enc_r(0, 1, 2, 6'h20);
    prog[4] = enc_j(4);
    load_all();
    release_rst();
    step(5);
    peek(0, v);
    chk(v == 32'd0, "R8", "r0 after writes", v, 0);
    peek(2, v);
    chk(v == 32'hDEAD_BEEF, "R8", "r0 reads zero as operand", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    clear_arrays();
    data[0] = 32'd9;
    data[1] = 32'd3;
    prog[0] = enc_i(6'h23, 0, 5, 0);
    prog[1] = enc_i(6'h23, 0, 1, 4);
    prog[2] = 32'hFC21_0004;
    prog[3] = enc_r(1, 1, 5, 6'h00);
    prog[4] = enc_j(4);
    load_all();
    release_rst();
    step(2);
    chk(!rf_we_o && !dm_we_o, "R9", "unknown opcode quiet", {rf_we_o, dm_we_o}, 0);
    step(1);
    chk(pc_o == 32'd12, "R9", "unknown opcode advances pc", pc_o, 12);
    chk(!rf_we_o && !dm_we_o, "R9", "unknown funct quiet", {rf_we_o, dm_we_o}, 0);
    step(2);
    peek(5, v);
    chk(v == 32'd9, "R9", "r5 untouched", v, 9);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_zero();
    t_unknown();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule